// File: doc/BRIEF.md
# Tablewalk address assist

This block shortens a software page-table walk that runs after a data translation miss. When the miss happens, the block captures the effective page number of the faulting access. The miss handler can then get the address of each page-table entry it has to fetch by reading a register, with no shifting or masking in software.

The handler first writes the base of the first-level table. Reading the table-base register then returns the address of the first-level entry for the faulting page. The handler fetches that entry and writes it into the segment register. Reading the segment register then returns the address of the second-level entry. A one-bit control register turns the second-level assist on or off, and the assist is on after reset. A scratch word lets the handler save a working register while it walks the tables.

Memory access and the loading of translation entries happen outside this block.

Top module: `twa_assist`

## Requirements
- R1: After a clock edge with `rst_n` low, the table base, the segment word, the scratch word and the captured page number are all zero, and the assist-mode bit is 1.
- R2: A write with `wr_sel` = 0 keeps only bits 31:12 of `wr_data` as the first-level base.
- R3: Reading with `rd_sel` = 0 returns the first-level entry address. Bits 31:12 are the base, bits 11:2 are bits 31:22 of the captured effective address (page-number bits 19:10), and bits 1:0 are 00.
- R4: Reading with `rd_sel` = 1 while the assist bit is 1 returns the second-level entry address. Bits 31:12 are the segment word's bits 31:12, bits 11:2 are bits 21:12 of the captured effective address (page-number bits 9:0), and bits 1:0 are 00.
- R5: Reading with `rd_sel` = 1 while the assist bit is 0 returns the segment word exactly as it was written with `wr_sel` = 1.
- R6: A write with `wr_sel` = 2 sets the assist bit from `wr_data` bit 0. Reading with `rd_sel` = 2 returns the assist bit in bit 0, with all other bits 0.
- R7: A write with `wr_sel` = 3 stores the whole word as scratch, and reading with `rd_sel` = 3 returns it. A scratch write changes no other register's read value.
- R8: `miss_epn` is captured only at a clock edge where `miss_valid` is high. Register reads and writes never change the captured value.
- R9: A write or a capture takes effect at the next rising clock edge. `rd_data` follows `rd_sel` combinationally, with no cycle of delay.
- R10: A register write and a miss capture in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 base, 1 segment, 2 control, 3 scratch |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 2 | Read source, same encoding as `wr_sel` |
| rd_data | output | DATA_W | Read data (a computed address for selects 0 and 1) |
| miss_valid | input | 1 | Data-miss event; captures `miss_epn` |
| miss_epn | input | DATA_W-PAGE_SHIFT | Effective page number of the faulting access |

## Verification
The bench builds the block with its default parameters: a 32-bit word, 4 KiB pages and 4-byte entries. With these values each of the two index fields is 10 bits wide, and the two fields together cover the whole 20-bit page number. The bench therefore checks exact bit placement at both levels, including the point where the first-level index ends and the second-level index begins. It also checks the assist-off pass-through of the segment word and the behaviour when a write and a miss capture fall in the same cycle.

// File: rtl/twa_pkg.sv
// Shared register-select encoding for the tablewalk address assist.
package twa_pkg;
    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_SEG  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_SCR  = 2'd3
    } twa_sel_e;
endpackage

// File: rtl/twa_regfile.sv
// Software-written state: the first-level base (page-number bits only), the
// full segment word, the assist-mode bit and the scratch word.
// Assumes a single write port. Writes land on the rising edge.
module twa_regfile #(
    parameter int DATA_W     = 32,
    parameter int PAGE_SHIFT = 12,
    localparam int EPN_W     = DATA_W - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [EPN_W-1:0]  base_q,
    output logic [DATA_W-1:0] seg_q,
    output logic              mode_q,
    output logic [DATA_W-1:0] scr_q
);
    import twa_pkg::*;

    twa_sel_e sel;
    assign sel = twa_sel_e'(wr_sel);

    // Update the addressed register on a write; reset clears the words and sets assist mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            seg_q  <= '0;
            mode_q <= 1'b1;
            scr_q  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_BASE: base_q <= wr_data[DATA_W-1:PAGE_SHIFT];
                SEL_SEG:  seg_q  <= wr_data;
                SEL_CTRL: mode_q <= wr_data[0];
                SEL_SCR:  scr_q  <= wr_data;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/twa_ea_latch.sv
// Holds the effective page number of the last data miss.
// Assumes miss_valid is a single-cycle or level event. It captures on every
// edge where it is high and is blind to register traffic.
module twa_ea_latch #(
    parameter int EPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_valid,
    input  logic [EPN_W-1:0] miss_epn,
    output logic [EPN_W-1:0] ea_q
);
    // Capture the faulting page number on a miss, otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q <= '0;
        end else if (miss_valid) begin
            ea_q <= miss_epn;
        end
    end
endmodule

// File: rtl/twa_addr_gen.sv
// Combinational read path. It builds the first-level and second-level entry
// addresses from the stored bases and the captured page number, then selects
// the read word. Assumes EPN_W == 2*IDX_W, so the two index fields together
// cover the whole page number.
module twa_addr_gen #(
    parameter int DATA_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int ENT_SHIFT  = 2,
    localparam int EPN_W     = DATA_W - PAGE_SHIFT,
    localparam int IDX_W     = PAGE_SHIFT - ENT_SHIFT
) (
    input  logic [1:0]        rd_sel,
    input  logic [EPN_W-1:0]  base_q,
    input  logic [DATA_W-1:0] seg_q,
    input  logic              mode_q,
    input  logic [DATA_W-1:0] scr_q,
    input  logic [EPN_W-1:0]  ea_q,
    output logic [DATA_W-1:0] rd_data
);
    import twa_pkg::*;

    logic [IDX_W-1:0]  l1_idx;
    logic [IDX_W-1:0]  l2_idx;
    logic [DATA_W-1:0] l1_addr;
    logic [DATA_W-1:0] l2_addr;
    logic [DATA_W-1:0] seg_rd;

    assign l1_idx  = ea_q[EPN_W-1 -: IDX_W];
    assign l2_idx  = ea_q[EPN_W-IDX_W-1 -: IDX_W];
    assign l1_addr = {base_q, l1_idx, {ENT_SHIFT{1'b0}}};
    assign l2_addr = {seg_q[DATA_W-1:PAGE_SHIFT], l2_idx, {ENT_SHIFT{1'b0}}};
    assign seg_rd  = mode_q ? l2_addr : seg_q;

    // Select the word returned for the current read address.
    always_comb begin
        case (twa_sel_e'(rd_sel))
            SEL_BASE: rd_data = l1_addr;
            SEL_SEG:  rd_data = seg_rd;
            SEL_CTRL: rd_data = {{(DATA_W-1){1'b0}}, mode_q};
            SEL_SCR:  rd_data = scr_q;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/twa_assist.sv
// Top of the tablewalk address assist. It ties together the register file,
// the fault-address latch and the read-path address composer.
// Assumes DATA_W - PAGE_SHIFT == 2*(PAGE_SHIFT - ENT_SHIFT).
module twa_assist #(
    parameter int DATA_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int ENT_SHIFT  = 2,
    localparam int EPN_W     = DATA_W - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              miss_valid,
    input  logic [EPN_W-1:0]  miss_epn
);
    logic [EPN_W-1:0]  base_q;
    logic [DATA_W-1:0] seg_q;
    logic              mode_q;
    logic [DATA_W-1:0] scr_q;
    logic [EPN_W-1:0]  ea_q;

    twa_regfile #(.DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .base_q(base_q), .seg_q(seg_q),
        .mode_q(mode_q), .scr_q(scr_q)
    );

    twa_ea_latch #(.EPN_W(EPN_W)) ea_i (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid),
        .miss_epn(miss_epn), .ea_q(ea_q)
    );

    twa_addr_gen #(.DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT), .ENT_SHIFT(ENT_SHIFT)) gen_i (
        .rd_sel(rd_sel), .base_q(base_q), .seg_q(seg_q), .mode_q(mode_q),
        .scr_q(scr_q), .ea_q(ea_q), .rd_data(rd_data)
    );
endmodule

// File: rtl/twa_assist_chk.sv
// Assertion checker for twa_assist, attached to it by bind.
module twa_assist_chk #(
    parameter int DATA_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int ENT_SHIFT  = 2,
    localparam int EPN_W     = DATA_W - PAGE_SHIFT,
    localparam int IDX_W     = PAGE_SHIFT - ENT_SHIFT
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [1:0]        rd_sel,
    input logic [DATA_W-1:0] rd_data,
    input logic              miss_valid,
    input logic [EPN_W-1:0]  miss_epn,
    input logic [EPN_W-1:0]  ea_q,
    input logic              mode_q
);
    // After any reset edge the assist bit is set.
    assert_mode_reset_R1: assert property (@(posedge clk) !rst_n |=> mode_q);

    // The captured page number holds when no miss is signalled.
    assert_ea_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_valid |=> $stable(ea_q));

    // A miss captures the offered page number.
    assert_ea_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |=> ea_q == $past(miss_epn));

    // A first-level read carries the upper index and zero entry-offset bits.
    assert_l1_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel == 2'd0 |-> (rd_data[PAGE_SHIFT-1:ENT_SHIFT] == ea_q[EPN_W-1 -: IDX_W]
                            && rd_data[ENT_SHIFT-1:0] == '0));

    // A second-level read in assist mode carries the lower index.
    assert_l2_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd1 && mode_q) |->
            (rd_data[PAGE_SHIFT-1:ENT_SHIFT] == ea_q[EPN_W-IDX_W-1 -: IDX_W]
             && rd_data[ENT_SHIFT-1:0] == '0));

    // A scratch write is read back unchanged on the following cycle.
    assert_scratch_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) ##1 (rd_sel == 2'd3) |-> rd_data == $past(wr_data));
endmodule

bind twa_assist twa_assist_chk #(.DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT), .ENT_SHIFT(ENT_SHIFT)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .miss_valid(miss_valid), .miss_epn(miss_epn),
    .ea_q(ea_q), .mode_q(mode_q)
);

// File: tb/twa_assist_tb_top.sv
// Bench for twa_assist. A behavioural model is updated on every clock and
// compared against all four read selections before and after each edge.
module twa_assist_tb_top;
    localparam int CLK_PERIOD = 20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic [1:0]  rd_sel;
    logic [31:0] rd_data;
    logic        miss_valid;
    logic [19:0] miss_epn;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [19:0] m_base;
    logic [31:0] m_seg;
    logic        m_mode;
    logic [31:0] m_scr;
    logic [19:0] m_ea;

    always #(CLK_PERIOD/2) clk = ~clk;

    twa_assist dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .miss_valid(miss_valid), .miss_epn(miss_epn)
    );

    function automatic logic [31:0] expect_rd(int s);
        case (s)
            0: return {m_base, m_ea[19:10], 2'b00};
            1: return m_mode ? {m_seg[31:12], m_ea[9:0], 2'b00} : m_seg;
            2: return {31'd0, m_mode};
            default: return m_scr;
        endcase
    endfunction

    function automatic string req_of(int s);
        case (s)
            0: return "R3";
            1: return m_mode ? "R4" : "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare every read selection against the model (combinational, R9).
    task automatic check_all(string ctx);
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1;
            chk($sformatf("%s/%s sel=%0d", req_of(s), ctx, s), rd_data, expect_rd(s));
        end
    endtask

    // One clock: drive, check the old state before the edge, update the model, check after.
    task automatic step(logic rst, logic we, logic [1:0] sel, logic [31:0] d,
                        logic mv, logic [19:0] ea, string ctx);
        rst_n = rst; wr_en = we; wr_sel = sel; wr_data = d;
        miss_valid = mv; miss_epn = ea;
        if (rst) check_all({ctx, " pre-edge R9"});
        @(posedge clk);
        if (!rst) begin
            m_base = '0; m_seg = '0; m_mode = 1'b1; m_scr = '0; m_ea = '0;
        end else begin
            if (we) begin
                case (sel)
                    2'd0: m_base = d[31:12];
                    2'd1: m_seg  = d;
                    2'd2: m_mode = d[0];
                    default: m_scr = d;
                endcase
            end
            if (mv) m_ea = ea;
        end
        @(negedge clk);
        if (rst) check_all(ctx);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        rd_sel = '0; miss_valid = 1'b0; miss_epn = '0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 20'h0, "reset");
        check_all("R1 after reset");
        rd_sel = 2'd2; #1;
        chk("R1 assist bit after reset", rd_data, 32'h1);

        step(1'b1, 1'b1, 2'd0, 32'h1234_5FFF, 1'b0, 20'h0, "R2 base write low bits dropped");
        step(1'b1, 1'b0, 2'd0, 32'h0, 1'b1, 20'hFFC01, "R8 miss capture");
        step(1'b1, 1'b0, 2'd0, 32'h0, 1'b0, 20'h00000, "R8 hold without miss");
        step(1'b1, 1'b1, 2'd1, 32'hABCD_E7F3, 1'b0, 20'h55555, "R4 segment write");
        step(1'b1, 1'b1, 2'd3, 32'hDEAD_BEEF, 1'b0, 20'hAAAAA, "R7 scratch isolation");
        step(1'b1, 1'b1, 2'd2, 32'hFFFF_FFFE, 1'b0, 20'h0, "R5 assist off");
        step(1'b1, 1'b1, 2'd1, 32'h0000_0FFF, 1'b0, 20'h0, "R5 raw segment");
        step(1'b1, 1'b1, 2'd2, 32'h0000_0001, 1'b0, 20'h0, "R6 assist on");
        step(1'b1, 1'b1, 2'd0, 32'hFFFF_F000, 1'b1, 20'h003FF, "R10 write with miss");
        step(1'b1, 1'b1, 2'd1, 32'h8000_1000, 1'b1, 20'hFFC00, "R10 segment with miss");
        step(1'b1, 1'b0, 2'd0, 32'h0, 1'b1, 20'h80200, "R8 index boundary");
        step(1'b1, 1'b0, 2'd0, 32'h0, 1'b0, 20'h0, "R8 hold");

        for (int i = 0; i < 300; i++) begin
            step(1'b1, 1'($urandom), 2'($urandom), $urandom, 1'($urandom),
                 20'($urandom), "random R2 R8 R10");
        end

        step(1'b0, 1'b1, 2'd3, 32'h1111_1111, 1'b1, 20'hFFFFF, "reset again");
        check_all("R1 second reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule